// File: doc/BRIEF.md
# YCbCr 4:2:2 Pixel Capture and Chroma Demultiplexer

This block sits at the input of a video encoder and takes in pixel data from an upstream decoder. Luma arrives on one 8-bit bus. Cb and Cr samples share a second 8-bit bus and alternate on it. No clock comes in with the data, so the block produces its own line timing. That timing is a line-start sync pulse (active low) and a half-rate pixel phase signal, both clocked from the double-rate pixel clock. The decoder uses them to launch its data. Capture of the active pixels begins a fixed number of double-rate cycles after the sync pulse falls. A pixel is taken only in the phase where the half-rate pixel signal is low.

Each captured chroma byte is tagged as Cb or Cr. Two sources can set the tag, and an active-low select-enable input picks between them. With select-enable high, a per-line pixel parity counter sets the tag: even pixels carry Cb and odd pixels carry Cr, and the parity restarts at every sync fall. With select-enable low, an external Cr-select line sets the tag. On the board both of these inputs are pulled high, so parity ordering is the default.

A Cb sample is held together with its luma until a Cr sample arrives. The block then presents both luma values and the two chroma values as one aligned 4:2:2 group, with a one-cycle valid strobe. Chroma leaves the block in signed form, with the offset of 128 removed.

Top module: `ycc_capture_demux`

## Requirements
- R1: `hsync_n_o` is low for the first HS_WIDTH cycles of each line and high for the rest. A line lasts LINE_CLKS double-rate cycles. The first fall comes one cycle after the internal reset release.
- R2: Counting line position from 0 at the cycle where `hsync_n_o` first reads low, `pclk_o` is low at even positions and high at odd positions. It therefore toggles every cycle.
- R3: Pixel k (0 ≤ k < ACTIVE_PIX) is sampled from `luma_i`, `chroma_i` and `cr_sel_i` at the rising edge that ends line position CAP_OFFSET+2k. Input values at every other position have no effect on the outputs.
- R4: With `sel_en_n_i` = 1, an even pixel index is Cb and an odd pixel index is Cr. `cr_sel_i` is ignored in this mode.
- R5: With `sel_en_n_i` = 0, a sample taken with `cr_sel_i` = 1 is Cr and a sample taken with `cr_sel_i` = 0 is Cb.
- R6: A Cr sample that finds a held Cb produces one group. `pair_vld_o` is high for exactly the one cycle after the sampling edge. In that cycle `y_even_o` carries the luma captured with the Cb and `y_odd_o` carries the luma captured with the Cr.
- R7: `cb_o` and `cr_o` equal the captured chroma code minus 128, written as 8-bit two's complement. Luma passes through unchanged.
- R8: A Cr sample with no held Cb produces no group. A Cb sample that arrives while a Cb is already held replaces the held Cb and its luma.
- R9: Each sync fall discards any held Cb and restarts the pixel parity at even.
- R10: While `rst_n` is low, `hsync_n_o` and `pclk_o` read 1 and `pair_vld_o` and the four data outputs read 0. Reset assertion acts without a clock edge. Release passes through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_2x | input | 1 | Double-rate pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| luma_i | input | 8 | Luma sample from the decoder |
| chroma_i | input | 8 | Multiplexed Cb/Cr sample from the decoder |
| sel_en_n_i | input | 1 | Low: `cr_sel_i` sets the chroma identity; high: pixel parity sets it |
| cr_sel_i | input | 1 | External chroma identity, 1 = Cr |
| hsync_n_o | output | 1 | Generated line sync, active low |
| pclk_o | output | 1 | Half-rate pixel phase, low during capture phase |
| pair_vld_o | output | 1 | One-cycle strobe for a complete Y/Y/Cb/Cr group |
| y_even_o | output | 8 | Luma captured with the Cb sample |
| y_odd_o | output | 8 | Luma captured with the Cr sample |
| cb_o | output | 8 | Signed Cb (code − 128) |
| cr_o | output | 8 | Signed Cr (code − 128) |

## Verification
The checker runs on every cycle and checks four things:
- `pclk_o` alternates each cycle.
- A sample is never taken while `pclk_o` is high.
- Every group strobe follows a Cr sample that found a held Cb, and strobes are never back to back.
- Each sync fall leaves no Cb held.

Some behaviours can only be shown by the bench scenarios:
- The exact capture offset and sampling phase. The bench drives unrelated values in the off phases.
- The signed conversion, swept over all 256 chroma codes.
- Orphan-Cr dropping and Cb replacement under the external select.
- Group counts that depend on the chroma identity restarting at each line.

// File: rtl/ycc_cap_pkg.sv
package ycc_cap_pkg;

  typedef enum logic {
    CHROMA_BLUE = 1'b0,
    CHROMA_RED  = 1'b1
  } chroma_kind_e;

  typedef struct packed {
    logic [7:0]   luma;
    logic [7:0]   chroma;
    chroma_kind_e kind;
  } cap_sample_t;

  // Offset-binary chroma code to two's complement (code - 128).
  function automatic logic [7:0] offset_to_signed(input logic [7:0] code);
    return code - 8'd128;
  endfunction

endpackage

// File: rtl/ycc_rst_sync.sv
module ycc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ycc_line_timer.sv
module ycc_line_timer #(
  parameter int LINE_CLKS  = 1716,
  parameter int HS_WIDTH   = 64,
  parameter int CAP_OFFSET = 64,
  parameter int ACTIVE_PIX = 720
) (
  input  logic clk,
  input  logic rst_n,
  output logic hsync_n_o,
  output logic pclk_o,
  output logic line_start_o,
  output logic sample_en_o
);

  localparam int CW      = $clog2(LINE_CLKS);
  localparam int LAST    = LINE_CLKS - 1;
  localparam int CAP_END = CAP_OFFSET + 2 * ACTIVE_PIX;
  localparam logic [CW-1:0] LAST_POS = CW'(LAST);
  localparam logic LAST_PH = LAST_POS[0];

  logic [CW-1:0] pos_q, pos_d;
  logic          hs_n_q, hs_n_d;
  logic          ph_q, ph_d;
  logic [31:0]   pos_w, pos_d_w;

  // Next-state
  always_comb begin
    pos_d   = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
    pos_d_w = 32'(pos_d);
    hs_n_d  = !(pos_d_w < 32'(HS_WIDTH));
    ph_d    = pos_d[0];
  end

  // Registers; reset parks the line at its final cycle so the
  // first enabled edge starts a fresh line.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= LAST_POS;
      hs_n_q <= 1'b1;
      ph_q   <= LAST_PH;
    end else begin
      pos_q  <= pos_d;
      hs_n_q <= hs_n_d;
      ph_q   <= ph_d;
    end
  end

  always_comb begin
    pos_w        = 32'(pos_q);
    line_start_o = (pos_q == '0);
    sample_en_o  = (pos_w >= 32'(CAP_OFFSET)) && (pos_w < 32'(CAP_END)) && !pos_q[0];
  end

  assign hsync_n_o = hs_n_q;
  assign pclk_o    = ph_q;

endmodule

// File: rtl/ycc_chroma_steer.sv
module ycc_chroma_steer
  import ycc_cap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_start_i,
  input  logic        sample_en_i,
  input  logic        sel_en_n_i,
  input  logic        cr_sel_i,
  input  logic [7:0]  luma_i,
  input  logic [7:0]  chroma_i,
  output cap_sample_t smp_o,
  output logic        smp_vld_o
);

  logic parity_q, parity_d;

  always_comb begin
    parity_d = parity_q;
    if (line_start_i)     parity_d = 1'b0;
    else if (sample_en_i) parity_d = ~parity_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) parity_q <= 1'b0;
    else        parity_q <= parity_d;
  end

  always_comb begin
    smp_o.luma   = luma_i;
    smp_o.chroma = chroma_i;
    smp_o.kind   = sel_en_n_i ? chroma_kind_e'(parity_q) : chroma_kind_e'(cr_sel_i);
    smp_vld_o    = sample_en_i;
  end

endmodule

// File: rtl/ycc_pair_assemble.sv
module ycc_pair_assemble
  import ycc_cap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_start_i,
  input  cap_sample_t smp_i,
  input  logic        smp_vld_i,
  output logic        have_cb_o,
  output logic        vld_o,
  output logic [7:0]  y_even_o,
  output logic [7:0]  y_odd_o,
  output logic [7:0]  cb_o,
  output logic [7:0]  cr_o
);

  logic       have_q, have_d;
  logic [7:0] hold_y_q, hold_y_d;
  logic [7:0] hold_cb_q, hold_cb_d;
  logic       vld_q, vld_d;
  logic [7:0] ye_q, ye_d, yo_q, yo_d, cb_q, cb_d, cr_q, cr_d;

  always_comb begin
    have_d    = have_q;
    hold_y_d  = hold_y_q;
    hold_cb_d = hold_cb_q;
    vld_d     = 1'b0;
    ye_d      = ye_q;
    yo_d      = yo_q;
    cb_d      = cb_q;
    cr_d      = cr_q;
    if (line_start_i) begin
      have_d = 1'b0;
    end else if (smp_vld_i) begin
      if (smp_i.kind == CHROMA_BLUE) begin
        have_d    = 1'b1;
        hold_y_d  = smp_i.luma;
        hold_cb_d = smp_i.chroma;
      end else if (have_q) begin
        have_d = 1'b0;
        vld_d  = 1'b1;
        ye_d   = hold_y_q;
        yo_d   = smp_i.luma;
        cb_d   = offset_to_signed(hold_cb_q);
        cr_d   = offset_to_signed(smp_i.chroma);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q    <= 1'b0;
      hold_y_q  <= '0;
      hold_cb_q <= '0;
      vld_q     <= 1'b0;
      ye_q      <= '0;
      yo_q      <= '0;
      cb_q      <= '0;
      cr_q      <= '0;
    end else begin
      have_q    <= have_d;
      hold_y_q  <= hold_y_d;
      hold_cb_q <= hold_cb_d;
      vld_q     <= vld_d;
      ye_q      <= ye_d;
      yo_q      <= yo_d;
      cb_q      <= cb_d;
      cr_q      <= cr_d;
    end
  end

  assign have_cb_o = have_q;
  assign vld_o     = vld_q;
  assign y_even_o  = ye_q;
  assign y_odd_o   = yo_q;
  assign cb_o      = cb_q;
  assign cr_o      = cr_q;

endmodule

// File: rtl/ycc_capture_demux.sv
module ycc_capture_demux
  import ycc_cap_pkg::*;
#(
  parameter int LINE_CLKS  = 1716,
  parameter int HS_WIDTH   = 64,
  parameter int CAP_OFFSET = 64,
  parameter int ACTIVE_PIX = 720,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_2x,
  input  logic       rst_n,
  input  logic [7:0] luma_i,
  input  logic [7:0] chroma_i,
  input  logic       sel_en_n_i,
  input  logic       cr_sel_i,
  output logic       hsync_n_o,
  output logic       pclk_o,
  output logic       pair_vld_o,
  output logic [7:0] y_even_o,
  output logic [7:0] y_odd_o,
  output logic [7:0] cb_o,
  output logic [7:0] cr_o
);

  logic        rst_sync_n;
  logic        line_start;
  logic        sample_en;
  cap_sample_t smp;
  logic        smp_vld;
  logic        smp_is_cr;
  logic        have_cb;

  ycc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk_2x),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ycc_line_timer #(
    .LINE_CLKS  (LINE_CLKS),
    .HS_WIDTH   (HS_WIDTH),
    .CAP_OFFSET (CAP_OFFSET),
    .ACTIVE_PIX (ACTIVE_PIX)
  ) u_timer (
    .clk          (clk_2x),
    .rst_n        (rst_sync_n),
    .hsync_n_o    (hsync_n_o),
    .pclk_o       (pclk_o),
    .line_start_o (line_start),
    .sample_en_o  (sample_en)
  );

  ycc_chroma_steer u_steer (
    .clk          (clk_2x),
    .rst_n        (rst_sync_n),
    .line_start_i (line_start),
    .sample_en_i  (sample_en),
    .sel_en_n_i   (sel_en_n_i),
    .cr_sel_i     (cr_sel_i),
    .luma_i       (luma_i),
    .chroma_i     (chroma_i),
    .smp_o        (smp),
    .smp_vld_o    (smp_vld)
  );

  assign smp_is_cr = (smp.kind == CHROMA_RED);

  ycc_pair_assemble u_pair (
    .clk          (clk_2x),
    .rst_n        (rst_sync_n),
    .line_start_i (line_start),
    .smp_i        (smp),
    .smp_vld_i    (smp_vld),
    .have_cb_o    (have_cb),
    .vld_o        (pair_vld_o),
    .y_even_o     (y_even_o),
    .y_odd_o      (y_odd_o),
    .cb_o         (cb_o),
    .cr_o         (cr_o)
  );

endmodule

// File: rtl/ycc_capture_demux_chk.sv
module ycc_capture_demux_chk (
  input logic clk,
  input logic rst_n,
  input logic hsync_n,
  input logic pclk,
  input logic sample_en,
  input logic smp_is_cr,
  input logic have_cb,
  input logic pair_vld
);

  // R2: phase output alternates every cycle
  assert_pclk_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pclk |=> pclk);
  assert_pclk_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pclk |=> !pclk);

  // R3: sampling only in the low phase of the pixel clock
  assert_sample_low_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> !pclk);

  // R6 / R8: a group needs a Cr sample meeting a held Cb
  assert_group_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld |-> ($past(have_cb) && $past(sample_en) && $past(smp_is_cr)));

  // R6: strobe lasts a single cycle
  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld |=> !pair_vld);

  // R9: sync fall drops any held Cb
  assert_line_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync_n) |=> !have_cb);

endmodule

bind ycc_capture_demux ycc_capture_demux_chk u_chk (
  .clk       (clk_2x),
  .rst_n     (rst_sync_n),
  .hsync_n   (hsync_n_o),
  .pclk      (pclk_o),
  .sample_en (sample_en),
  .smp_is_cr (smp_is_cr),
  .have_cb   (have_cb),
  .pair_vld  (pair_vld_o)
);

// File: tb/sim_ycc_capture_demux.sv
module sim_ycc_capture_demux;

  localparam int LINE = 32;
  localparam int HSW  = 4;
  localparam int CAP  = 6;
  localparam int NPIX = 8;

  logic       clk_2x = 1'b0;
  logic       rst_n;
  logic [7:0] luma_i, chroma_i;
  logic       sel_en_n_i, cr_sel_i;
  logic       hsync_n_o, pclk_o, pair_vld_o;
  logic [7:0] y_even_o, y_odd_o, cb_o, cr_o;

  always #4 clk_2x = ~clk_2x;

  ycc_capture_demux #(
    .LINE_CLKS(LINE), .HS_WIDTH(HSW), .CAP_OFFSET(CAP), .ACTIVE_PIX(NPIX)
  ) u0 (
    .clk_2x(clk_2x), .rst_n(rst_n), .luma_i(luma_i), .chroma_i(chroma_i),
    .sel_en_n_i(sel_en_n_i), .cr_sel_i(cr_sel_i), .hsync_n_o(hsync_n_o),
    .pclk_o(pclk_o), .pair_vld_o(pair_vld_o), .y_even_o(y_even_o),
    .y_odd_o(y_odd_o), .cb_o(cb_o), .cr_o(cr_o)
  );

  int checks = 0, fails = 0, t = 0, line_pairs = 0;
  bit synced = 0, hs_prev = 1, done = 0;
  bit exp_vld = 0, m_have = 0;
  logic [7:0] e_y0, e_y1, e_cb, e_cr, m_y, m_cb, sweep = 8'd0;
  string chroma_req = "R4";

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_2x);
    if (hs_prev && !hsync_n_o) begin
      if (synced) chk(t == LINE - 1, "R1", "line period", t + 1, LINE);
      synced = 1;
      t = 0;
    end else begin
      t++;
    end
    hs_prev = hsync_n_o;
    if (synced) begin
      chk(hsync_n_o == (t >= HSW), "R1", "sync level", hsync_n_o, int'(t >= HSW));
      chk(pclk_o == t[0], "R2", "pixel phase", pclk_o, t[0]);
      chk(pair_vld_o == exp_vld, "R6", "group strobe", pair_vld_o, exp_vld);
      if (pair_vld_o) line_pairs++;
      if (exp_vld && pair_vld_o) begin
        chk(y_even_o == e_y0, "R3", "luma with Cb", y_even_o, e_y0);
        chk(y_odd_o  == e_y1, "R6", "luma with Cr", y_odd_o, e_y1);
        chk(cb_o == e_cb, chroma_req, "signed Cb (R7)", cb_o, e_cb);
        chk(cr_o == e_cr, chroma_req, "signed Cr (R7)", cr_o, e_cr);
      end
    end
    exp_vld = 0;
  endtask

  task automatic drive(input int pat);
    bit cs, is_cr;
    int k;
    logic [7:0] y, c;
    if (t == 0) m_have = 0;  // R9 model: line start drops held Cb
    if (t >= CAP && t < CAP + 2 * NPIX && t % 2 == 0) begin
      k = (t - CAP) / 2;
      if (pat == 0) begin
        c = sweep; sweep = sweep + 8'd1;
        y = 8'(16 + (int'(c) * 7) % 220);
      end else begin
        c = 8'($urandom); y = 8'($urandom);
      end
      case (pat)
        1: cs = k[0];
        2: cs = !k[0];
        4: cs = (k == 3 || k == 7);
        5: cs = 1'b1;
        default: cs = 1'($urandom);
      endcase
      is_cr = (pat == 0 || pat == 5) ? k[0] : cs;
      luma_i = y; chroma_i = c; cr_sel_i = cs;
      if (is_cr) begin
        if (m_have) begin
          exp_vld = 1; e_y0 = m_y; e_cb = m_cb - 8'd128;
          e_y1 = y; e_cr = c - 8'd128; m_have = 0;
        end
      end else begin
        m_have = 1; m_y = y; m_cb = c;
      end
    end else begin
      luma_i = 8'($urandom); chroma_i = 8'($urandom); cr_sel_i = 1'($urandom);
    end
  endtask

  task automatic run_line(input int pat, input int exp_pairs);
    sel_en_n_i = (pat == 0 || pat == 5);
    chroma_req = sel_en_n_i ? "R4" : "R5";
    line_pairs = 0;
    do begin
      drive(pat);
      step();
    end while (t != 0);
    if (exp_pairs >= 0)
      chk(line_pairs == exp_pairs,
          pat == 2 ? "R9" : (pat == 4 ? "R8" : chroma_req),
          "groups per line", line_pairs, exp_pairs);
  endtask

  initial begin
    rst_n = 1'b0; luma_i = '0; chroma_i = '0; sel_en_n_i = 1'b1; cr_sel_i = 1'b1;
    repeat (3) @(negedge clk_2x);
    chk(hsync_n_o == 1'b1, "R10", "reset sync", hsync_n_o, 1);
    chk(pclk_o == 1'b1, "R10", "reset phase", pclk_o, 1);
    chk(pair_vld_o == 1'b0, "R10", "reset strobe", pair_vld_o, 0);
    chk(y_even_o == 8'd0 && cb_o == 8'd0, "R10", "reset data", y_even_o, 0);
    rst_n = 1'b1;
    while (!synced) step();
    // R4/R7: parity ordering, full chroma code sweep
    for (int i = 0; i < 32; i++) run_line(0, 4);
    run_line(1, 4);   // R5 alternating, Cb first
    run_line(2, 3);   // R8 orphan Cr, R9 dangling Cb cleared
    run_line(2, 3);   // R9 again after a dangling Cb
    run_line(4, 2);   // R8 Cb replacement
    run_line(3, -1);  // R5 random selection
    run_line(3, -1);
    run_line(5, 4);   // R4 cr_sel held high, ignored
    run_line(1, 4);
    run_line(4, 2);
    // R10: asynchronous assertion between edges
    @(posedge clk_2x); #1;
    rst_n = 1'b0; #1;
    chk(hsync_n_o == 1'b1 && pclk_o == 1'b1 && pair_vld_o == 1'b0,
        "R10", "async reset", {hsync_n_o, pclk_o, pair_vld_o}, 6);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", t, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule